// File: doc/BRIEF.md
# Modem Control and Status Port

This block holds the modem-line side of a 16450-class serial port register file. Four active-low handshake inputs (clear-to-send, data-set-ready, ring indicator, carrier detect) pass through a two-flop synchronizer. Their inverted levels appear in the upper nibble of a status register. The lower nibble holds sticky change flags. A control register drives two active-low handshake outputs (request-to-send, data-terminal-ready) and two spare active-low outputs. A free scratch byte sits beside them. All three registers share a 3-bit address, 8-bit data bus with single-cycle write and read strobes. Read data is combinational and is zero when no read is strobed.

A two-state mode machine selects where the status nibble comes from. In MODE_NORMAL the status comes from the synchronized pins. In MODE_LOOP it comes from control register bits, so software can exercise the status path without external wiring. A write to the control address with bit 4 set takes the transition MODE_NORMAL to MODE_LOOP. A write with bit 4 clear takes MODE_LOOP back to MODE_NORMAL. An interrupt request goes high while any change flag is set and the external enable input is high.

Top module: `mdm_port_ctl`

## Requirements
- R1: After reset the control register reads 0x00, the scratch register reads 0xFF, the status low nibble is 0, `rts_n` and `dtr_n` are 1, and `ms_irq` is 0.
- R2: In MODE_NORMAL, status bits 7..4 at address 6 read the inverse of `cd_n`, `ri_n`, `dsr_n` and `cts_n` (bit 7 carrier, bit 6 ring, bit 5 data-set-ready, bit 4 clear-to-send), two clocks after a pin changes.
- R3: In MODE_LOOP (control bit 4 = 1), status bit 4 equals control bit 1, bit 5 equals control bit 0, bit 6 equals control bit 2, and bit 7 equals control bit 3. The pins are ignored.
- R4: Status bits 0, 1 and 3 are set by any change of the clear-to-send, data-set-ready and carrier status bits respectively.
- R5: Status bit 2 is set only when the ring status falls from 1 to 0. A rise leaves it clear.
- R6: Reading address 6 clears all four change flags. A flag whose event lands in the same cycle as that read is kept.
- R7: `ms_irq` is high exactly when `ms_irq_en` is 1 and any change flag is set. It goes low after the clearing read.
- R8: `dtr_n` = not control bit 0, `rts_n` = not control bit 1, `out1_n` = not control bit 2, `out2_n` = not control bit 3. In MODE_LOOP, `rts_n` and `dtr_n` are held at 1.
- R9: The scratch register at address 7 stores and returns every 8-bit value. The control register at address 4 returns bits 4..0 as written, and bits 7..5 read 0.
- R10: Writes to address 6 have no effect. Reads of addresses 0 to 3 and 5 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; a read of address 6 clears change flags |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |
| ms_irq_en | input | 1 | Modem-status interrupt enable |
| cts_n | input | 1 | Clear-to-send, active low |
| dsr_n | input | 1 | Data-set-ready, active low |
| ri_n | input | 1 | Ring indicator, active low |
| cd_n | input | 1 | Carrier detect, active low |
| rts_n | output | 1 | Request-to-send, active low |
| dtr_n | output | 1 | Data-terminal-ready, active low |
| out1_n | output | 1 | Spare output 1, active low |
| out2_n | output | 1 | Spare output 2, active low |
| ms_irq | output | 1 | Modem-status interrupt request |

## Verification
In normal mode the bench walks every ordered pair of the 16 pin patterns. This separates each line's change flag from its neighbours and tells a ring fall from a ring rise. In loopback it steps through all 16 control nibbles, which exposes any swap in the crossed control-to-status mapping. One pin change is timed to reach the change flag in the same cycle as a status read, which shows whether a set wins over the clear. All 256 scratch values, the unmapped addresses and a write to the status address round out the register checks.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 8;
    localparam int MCR_W  = 5;
    localparam int NLINES = 4;

    localparam logic [ADDR_W-1:0] A_MCR = 3'd4;
    localparam logic [ADDR_W-1:0] A_MSR = 3'd6;
    localparam logic [ADDR_W-1:0] A_SCR = 3'd7;

    // control register bit positions
    localparam int C_DTR  = 0;
    localparam int C_RTS  = 1;
    localparam int C_OUT1 = 2;
    localparam int C_OUT2 = 3;
    localparam int C_LOOP = 4;

    // status nibble positions (status register bits 4..7)
    localparam int S_CTS = 0;
    localparam int S_DSR = 1;
    localparam int S_RI  = 2;
    localparam int S_CD  = 3;

    typedef enum logic {
        MODE_NORMAL = 1'b0,
        MODE_LOOP   = 1'b1
    } mode_t;
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
    parameter int          WIDTH   = 4,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[g] <= RST_VAL;
                    else        stage_q[g] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[g] <= RST_VAL;
                    else        stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/mdm_ctrl_regs.sv
module mdm_ctrl_regs
    import mdm_pkg::*;
#(
    parameter logic [DATA_W-1:0] SCR_RST = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [MCR_W-1:0]  mcr_q,
    output logic [DATA_W-1:0] scratch_q,
    output mode_t             mode_q,
    output logic              rts_n,
    output logic              dtr_n,
    output logic              out1_n,
    output logic              out2_n
);
    mode_t mode_d;
    logic  mcr_wr;
    logic  scr_wr;

    assign mcr_wr = wr_en && (addr == A_MCR);
    assign scr_wr = wr_en && (addr == A_SCR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mcr_q     <= '0;
            scratch_q <= SCR_RST;
        end else begin
            if (mcr_wr) mcr_q     <= wdata[MCR_W-1:0];
            if (scr_wr) scratch_q <= wdata;
        end
    end

    // mode state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= MODE_NORMAL;
        else        mode_q <= mode_d;
    end

    // mode transitions
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_NORMAL: if (mcr_wr &&  wdata[C_LOOP]) mode_d = MODE_LOOP;
            MODE_LOOP:   if (mcr_wr && !wdata[C_LOOP]) mode_d = MODE_NORMAL;
            default:     mode_d = MODE_NORMAL;
        endcase
    end

    // mode outputs
    always_comb begin
        rts_n = 1'b1;
        dtr_n = 1'b1;
        unique case (mode_q)
            MODE_NORMAL: begin
                rts_n = ~mcr_q[C_RTS];
                dtr_n = ~mcr_q[C_DTR];
            end
            MODE_LOOP: begin
                rts_n = 1'b1;
                dtr_n = 1'b1;
            end
            default: ;
        endcase
    end

    assign out1_n = ~mcr_q[C_OUT1];
    assign out2_n = ~mcr_q[C_OUT2];
endmodule

// File: rtl/mdm_status.sv
module mdm_status
    import mdm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] lines_n,
    input  mode_t             mode_q,
    input  logic [MCR_W-1:0]  mcr_q,
    input  logic              msr_rd,
    input  logic              ms_irq_en,
    output logic [NLINES-1:0] stat_now,
    output logic [NLINES-1:0] stat_prev,
    output logic [NLINES-1:0] delta_q,
    output logic              ms_irq
);
    logic [NLINES-1:0] delta_set;
    logic [NLINES-1:0] delta_d;

    always_comb begin
        stat_now = '0;
        unique case (mode_q)
            MODE_NORMAL: stat_now = ~lines_n;
            MODE_LOOP: begin
                stat_now[S_CTS] = mcr_q[C_RTS];
                stat_now[S_DSR] = mcr_q[C_DTR];
                stat_now[S_RI]  = mcr_q[C_OUT1];
                stat_now[S_CD]  = mcr_q[C_OUT2];
            end
            default: ;
        endcase
    end

    always_comb begin
        delta_set        = stat_now ^ stat_prev;
        delta_set[S_RI]  = stat_prev[S_RI] & ~stat_now[S_RI];
        delta_d          = (msr_rd ? '0 : delta_q) | delta_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_prev <= '0;
            delta_q   <= '0;
        end else begin
            stat_prev <= stat_now;
            delta_q   <= delta_d;
        end
    end

    assign ms_irq = ms_irq_en & (|delta_q);
endmodule

// File: rtl/mdm_port_ctl.sv
module mdm_port_ctl
    import mdm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] addr,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic       ms_irq_en,
    input  logic       cts_n,
    input  logic       dsr_n,
    input  logic       ri_n,
    input  logic       cd_n,
    output logic       rts_n,
    output logic       dtr_n,
    output logic       out1_n,
    output logic       out2_n,
    output logic       ms_irq
);
    logic [NLINES-1:0] pins_raw;
    logic [NLINES-1:0] pins_sync;
    logic [MCR_W-1:0]  mcr_q;
    logic [DATA_W-1:0] scratch_q;
    mode_t             mode_q;
    logic [NLINES-1:0] stat_now;
    logic [NLINES-1:0] stat_prev;
    logic [NLINES-1:0] delta_q;
    logic              msr_rd;

    always_comb begin
        pins_raw        = '1;
        pins_raw[S_CTS] = cts_n;
        pins_raw[S_DSR] = dsr_n;
        pins_raw[S_RI]  = ri_n;
        pins_raw[S_CD]  = cd_n;
    end

    mdm_sync #(.WIDTH(NLINES), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pins_raw),
        .dout (pins_sync)
    );

    mdm_ctrl_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .mcr_q    (mcr_q),
        .scratch_q(scratch_q),
        .mode_q   (mode_q),
        .rts_n    (rts_n),
        .dtr_n    (dtr_n),
        .out1_n   (out1_n),
        .out2_n   (out2_n)
    );

    assign msr_rd = rd_en && (addr == A_MSR);

    mdm_status u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .lines_n  (pins_sync),
        .mode_q   (mode_q),
        .mcr_q    (mcr_q),
        .msr_rd   (msr_rd),
        .ms_irq_en(ms_irq_en),
        .stat_now (stat_now),
        .stat_prev(stat_prev),
        .delta_q  (delta_q),
        .ms_irq   (ms_irq)
    );

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            unique case (addr)
                A_MCR:   rdata = {{(DATA_W-MCR_W){1'b0}}, mcr_q};
                A_MSR:   rdata = {stat_now, delta_q};
                A_SCR:   rdata = scratch_q;
                default: rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/mdm_port_ctl_chk.sv
module mdm_port_ctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] addr,
    input logic       wr_en,
    input logic       rd_en,
    input logic [7:0] wdata,
    input logic       ms_irq_en,
    input logic       ms_irq,
    input logic       rts_n,
    input logic       dtr_n,
    input logic [3:0] stat_now,
    input logic [3:0] stat_prev,
    input logic [3:0] delta_q,
    input logic [7:0] scratch_q
);
    AST_CTS_CHANGE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_now[0] != stat_prev[0]) |=> delta_q[0]); // R4
    AST_CD_CHANGE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_now[3] != stat_prev[3]) |=> delta_q[3]); // R4
    AST_RING_FALL_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_prev[2] && !stat_now[2]) |=> delta_q[2]); // R5
    AST_RING_RISE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_prev[2] && stat_now[2] && !delta_q[2]) |=> !delta_q[2]); // R5
    AST_READ_CLEARS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 3'd6 && stat_now == stat_prev) |=> (delta_q == 4'd0)); // R6
    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !ms_irq_en |-> !ms_irq); // R7
    AST_LOOP_HOLDS_LINES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd4 && wdata[4]) |=> (rts_n && dtr_n)); // R8
    AST_SCRATCH_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == 3'd7) |=> $stable(scratch_q)); // R9
endmodule

bind mdm_port_ctl mdm_port_ctl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .wdata    (wdata),
    .ms_irq_en(ms_irq_en),
    .ms_irq   (ms_irq),
    .rts_n    (rts_n),
    .dtr_n    (dtr_n),
    .stat_now (stat_now),
    .stat_prev(stat_prev),
    .delta_q  (delta_q),
    .scratch_q(scratch_q)
);

// File: tb/mdm_port_ctl_test.sv
`timescale 1ns/100ps
module mdm_port_ctl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] addr = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       ms_irq_en = 1'b0;
    logic       cts_n = 1'b1, dsr_n = 1'b1, ri_n = 1'b1, cd_n = 1'b1;
    logic       rts_n, dtr_n, out1_n, out2_n, ms_irq;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    mdm_port_ctl uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .ms_irq_en(ms_irq_en),
        .cts_n(cts_n), .dsr_n(dsr_n), .ri_n(ri_n), .cd_n(cd_n),
        .rts_n(rts_n), .dtr_n(dtr_n), .out1_n(out1_n), .out2_n(out2_n),
        .ms_irq(ms_irq)
    );

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic set_pins(input logic [3:0] p);
        cts_n = p[0]; dsr_n = p[1]; ri_n = p[2]; cd_n = p[3];
    endtask

    function automatic logic [3:0] flags(input logic [3:0] o, input logic [3:0] n);
        logic [3:0] f;
        f[0] = o[0] ^ n[0];
        f[1] = o[1] ^ n[1];
        f[2] = o[2] & ~n[2];
        f[3] = o[3] ^ n[3];
        return f;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic [3:0] st_old, st_new, m_old;
        idle(3);
        rst_n = 1'b1;
        idle(3);
        // R1 reset state
        rd(3'd4, d); chk("R1 control reset", d, 8'h00);
        rd(3'd7, d); chk("R1 scratch reset", d, 8'hFF);
        rd(3'd6, d); chk("R1 status reset", d, 8'h00);
        #1;
        chk("R1 rts_n/dtr_n/irq", {5'd0, rts_n, dtr_n, ms_irq}, 8'b110);

        // R2 R4 R5 R7: every ordered pair of pin patterns
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                set_pins(a[3:0]);
                idle(4);
                rd(3'd6, d);
                st_old = ~a[3:0];
                chk("R2 status from pins", {4'd0, d[7:4]}, {4'd0, st_old});
                ms_irq_en = b[0] ^ a[1];
                set_pins(b[3:0]);
                idle(4);
                st_new = ~b[3:0];
                #1;
                chk("R7 irq before read", {7'd0, ms_irq},
                    {7'd0, ms_irq_en & (|flags(st_old, st_new))});
                rd(3'd6, d);
                chk("R4 R5 status and flags", d, {st_new, flags(st_old, st_new)});
                #1;
                chk("R7 irq after read", {7'd0, ms_irq}, 8'd0);
                rd(3'd6, d);
                chk("R6 flags cleared", {4'd0, d[3:0]}, 8'd0);
            end
        end

        // R6 event landing in the same cycle as the clearing read
        ms_irq_en = 1'b1;
        set_pins(4'hF);
        idle(4);
        rd(3'd6, d);
        set_pins(4'hE);          // clear-to-send becomes active
        idle(2);
        rd(3'd6, d);
        chk("R6 same-cycle read sees new level", d, 8'h10);
        rd(3'd6, d);
        chk("R6 same-cycle flag kept", d, 8'h11);
        set_pins(4'hF);
        idle(4);
        rd(3'd6, d);

        // R3 R8 loopback sweep over the control nibble
        m_old = 4'd0;
        for (int m = 0; m < 16; m++) begin
            logic [3:0] mm;
            mm = m[3:0];
            set_pins(~mm);       // pins opposite to loop values; must be ignored
            wr(3'd4, {3'b000, 1'b1, mm});
            idle(3);
            st_new = {mm[3], mm[2], mm[0], mm[1]};
            st_old = (m == 0) ? 4'd0 : {m_old[3], m_old[2], m_old[0], m_old[1]};
            rd(3'd6, d);
            chk("R3 loop mapping and flags", d, {st_new, flags(st_old, st_new)});
            #1;
            chk("R8 loop lines high", {4'd0, rts_n, dtr_n, out2_n, out1_n},
                {4'd0, 1'b1, 1'b1, ~mm[3], ~mm[2]});
            rd(3'd4, d);
            chk("R9 control readback", d, {3'b000, 1'b1, mm});
            m_old = mm;
        end
        set_pins(4'hF);
        wr(3'd4, 8'h00);
        idle(4);
        rd(3'd6, d);
        rd(3'd6, d);
        chk("R2 back to pins", d, 8'h00);

        // R8 normal-mode output mapping
        for (int m = 0; m < 16; m++) begin
            wr(3'd4, {4'd0, m[3:0]});
            #1;
            chk("R8 output mapping", {4'd0, out2_n, out1_n, rts_n, dtr_n}, {4'd0, ~m[3:0]});
        end
        wr(3'd4, 8'hE3);
        rd(3'd4, d);
        chk("R9 control upper bits read 0", d, 8'h03);
        wr(3'd4, 8'h00);
        idle(4);
        rd(3'd6, d);

        // R9 scratch full sweep
        for (int v = 0; v < 256; v++) begin
            wr(3'd7, v[7:0]);
            rd(3'd7, d);
            chk("R9 scratch", d, v[7:0]);
        end

        // R10 ignored writes, unmapped reads
        wr(3'd6, 8'hFF);
        idle(2);
        rd(3'd6, d);
        chk("R10 status write ignored", d, 8'h00);
        wr(3'd5, 8'h3C);
        rd(3'd7, d);
        chk("R10 scratch untouched", d, 8'hFF);
        rd(3'd4, d);
        chk("R10 control untouched", d, 8'h00);
        for (int a = 0; a < 6; a++) begin
            if (a != 4) begin
                rd(a[2:0], d);
                chk("R10 unmapped read", d, 8'h00);
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule